// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of one-cycle interrupt pulses and a handful of external pins, latches each into a per-source flag, and picks the single most urgent pending request to present to a processor. Every source is tied to one of a smaller set of vectors by a build-time table. Each vector holds a 3-bit level and a 2-bit sub-level. The controller registers a request line, the vector number and its level. It only does so while that level is strictly above the level the processor is running at.

Software reaches the flags, enables, levels and a control word through a small synchronous register port. Each register has four write flavours: plain write, clear-bits, set-bits and toggle-bits. Handlers clear flags themselves. The processor reports its running level on an input and pulses an acknowledge when it takes a request. A control bit switches between one shared vector (0) and per-vector reporting (1). A further control bit lets the block flag level-7 requests for an alternate register bank.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control word, flags, enables and all vector levels read 0, and `irq_o`, `irq_vec_o`, `irq_lvl_o` and `shadow_sel_o` are 0.
- R2: A source competes only when its flag and enable are both 1 and its vector's level is strictly greater than `cpu_lvl_i`. A source at or below the running level stays flagged and is requested as soon as `cpu_lvl_i` drops below its level, so an equal level never preempts.
- R3: A vector level of 0 keeps all its sources from ever being requested, even when they are flagged and enabled.
- R4: Among competing sources the higher level wins. At equal level the higher sub-level wins. At equal level and sub-level the lower source number wins.
- R5: Level and sub-level belong to the vector, so all sources mapped to one vector share them. The default table maps source s to vector s/4.
- R6: Control bit 8 set selects per-vector reporting. When it is clear (the reset value), `irq_vec_o` is 0 for every request.
- R7: Register address bits [1:0] pick the write flavour: 0 write, 1 clear where data is 1, 2 set where data is 1, 3 toggle where data is 1. Address bits [4:2] pick the register: 0 control, 1 flags, 2 enables, 3 and up hold vector levels. Each level register holds four vectors, one per byte, with the level in byte bits [4:2] and the sub-level in byte bits [1:0]. Reads ignore bits [1:0].
- R8: A pulse on `src_pulse_i` sets the matching flag. If a software clear of that flag lands in the same cycle, the flag ends up set.
- R9: External pin k sets the flag of source 24+k on a rising edge when control bit k is 1, or on a falling edge when it is 0. The opposite edge has no effect.
- R10: The request outputs are registered. They reflect the flag, enable and level state one clock after that state changes, and reflect `cpu_lvl_i` one clock after it changes.
- R11: In the cycle after `ack_i` is high, `irq_o` is 0 and `irq_vec_o` and `irq_lvl_o` read 0.
- R12: `shadow_sel_o` is 1 exactly when a request is presented at level 7 and control bit 12 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pulse_i | input | N_SRC | One-cycle set pulses, one per source |
| ext_pin_i | input | N_EXT | External pins with edge detection |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register index and write flavour |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| cpu_lvl_i | input | 3 | Processor running level |
| ack_i | input | 1 | Processor takes the current request |
| irq_o | output | 1 | Request to processor |
| irq_vec_o | output | VEC_W | Vector of the request |
| irq_lvl_o | output | 3 | Level of the request |
| shadow_sel_o | output | 1 | Alternate register bank select |

## Verification
A corrupted flag or enable bit becomes visible at the register port in the same cycle. It also moves `irq_o` or `irq_vec_o` one clock later, so each stimulus is followed by a scoreboard check at that exact edge. A wrong winner selection shows up as a wrong vector or level, so arbitration is checked with the level, sub-level and source-order ties that separate candidates one at a time. Broken level gating or a stuck acknowledge mask shows up as a request that appears or stays when it should not, and is seen within one clock of the change in `cpu_lvl_i` or `ack_i`.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } alias_op_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_FLAG = 1;
  localparam int unsigned REG_EN   = 2;
  localparam int unsigned REG_PRIO = 3;

  localparam int unsigned CTRL_MVEC_BIT   = 8;
  localparam int unsigned CTRL_SHADOW_BIT = 12;

  localparam int unsigned DEF_N_SRC = 32;
  localparam int unsigned DEF_VEC_W = 3;

  function automatic logic [31:0] alias_word(alias_op_e op, logic [31:0] old, logic [31:0] wd);
    case (op)
      OP_WRITE: return wd;
      OP_CLR:   return old & ~wd;
      OP_SET:   return old | wd;
      default:  return old ^ wd;
    endcase
  endfunction

  function automatic logic [4:0] alias_lane(alias_op_e op, logic [4:0] old, logic [4:0] wd);
    case (op)
      OP_WRITE: return wd;
      OP_CLR:   return old & ~wd;
      OP_SET:   return old | wd;
      default:  return old ^ wd;
    endcase
  endfunction

  // four consecutive sources per vector
  function automatic logic [DEF_N_SRC*DEF_VEC_W-1:0] default_map();
    logic [DEF_N_SRC*DEF_VEC_W-1:0] m;
    m = '0;
    for (int s = 0; s < int'(DEF_N_SRC); s++) m[s*DEF_VEC_W +: DEF_VEC_W] = DEF_VEC_W'(s / 4);
    return m;
  endfunction

endpackage

// File: rtl/ivc_edge_det.sv
module ivc_edge_det #(
  parameter int unsigned N_EXT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] rise_sel_i,
  output logic [N_EXT-1:0] hit_o
);

  logic [N_EXT-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  assign hit_o = (pin_i & ~prev_q & rise_sel_i) | (~pin_i & prev_q & ~rise_sel_i);

  // R9: a detected edge always leaves the pin at the selected level
  a_r9_hit_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & (pin_i ^ rise_sel_i)) == '0);

endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile import ivc_pkg::*; #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_VEC  = 8,
  parameter int unsigned N_EXT  = 5,
  parameter int unsigned ADDR_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [N_SRC-1:0]   hw_set_i,
  output logic [N_SRC-1:0]   flag_o,
  output logic [N_SRC-1:0]   en_o,
  output logic [N_VEC*3-1:0] prio_o,
  output logic [N_VEC*2-1:0] sub_o,
  output logic [N_EXT-1:0]   rise_sel_o,
  output logic               mvec_o,
  output logic               shadow_en_o
);

  localparam int unsigned IDX_W      = ADDR_W - 2;
  localparam int unsigned N_PRIO_REG = (N_VEC + 3) / 4;
  localparam logic [31:0] CTRL_MASK  = 32'((64'd1 << N_EXT) - 64'd1)
                                     | (32'd1 << CTRL_MVEC_BIT) | (32'd1 << CTRL_SHADOW_BIT);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(REG_CTRL);
  localparam logic [IDX_W-1:0] IDX_FLAG = IDX_W'(REG_FLAG);
  localparam logic [IDX_W-1:0] IDX_EN   = IDX_W'(REG_EN);

  logic [IDX_W-1:0] idx;
  alias_op_e        op;
  assign idx = addr_i[ADDR_W-1:2];
  assign op  = alias_op_e'(addr_i[1:0]);

  logic [31:0]      ctrl_q, ctrl_d;
  logic [N_SRC-1:0] flag_q, flag_d, en_q, en_d;
  logic [4:0]       prio_q [N_VEC];
  logic [4:0]       prio_d [N_VEC];
  logic [31:0]      flag_w, en_w, flag_new, en_new;
  logic [31:0]      prio_w [N_PRIO_REG];

  always_comb begin
    flag_w = '0;
    en_w   = '0;
    flag_w[N_SRC-1:0] = flag_q;
    en_w[N_SRC-1:0]   = en_q;
    for (int k = 0; k < int'(N_PRIO_REG); k++) begin
      prio_w[k] = '0;
      for (int l = 0; l < 4; l++)
        if (k*4 + l < int'(N_VEC)) prio_w[k][l*8 +: 5] = prio_q[k*4 + l];
    end
  end

  always_comb begin
    flag_new = alias_word(op, flag_w, wdata_i);
    en_new   = alias_word(op, en_w, wdata_i);
    ctrl_d   = ctrl_q;
    flag_d   = flag_q;
    en_d     = en_q;
    for (int v = 0; v < int'(N_VEC); v++) prio_d[v] = prio_q[v];
    if (we_i) begin
      if (idx == IDX_CTRL) ctrl_d = alias_word(op, ctrl_q, wdata_i) & CTRL_MASK;
      if (idx == IDX_FLAG) flag_d = flag_new[N_SRC-1:0];
      if (idx == IDX_EN)   en_d   = en_new[N_SRC-1:0];
      for (int k = 0; k < int'(N_PRIO_REG); k++)
        if (idx == IDX_W'(REG_PRIO + k))
          for (int l = 0; l < 4; l++)
            if (k*4 + l < int'(N_VEC))
              prio_d[k*4 + l] = alias_lane(op, prio_q[k*4 + l], wdata_i[l*8 +: 5]);
    end
    flag_d = flag_d | hw_set_i;  // hardware set wins over software clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= '0;
      en_q   <= '0;
      for (int v = 0; v < int'(N_VEC); v++) prio_q[v] <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      en_q   <= en_d;
      for (int v = 0; v < int'(N_VEC); v++) prio_q[v] <= prio_d[v];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx == IDX_CTRL) rdata_o = ctrl_q;
    if (idx == IDX_FLAG) rdata_o = flag_w;
    if (idx == IDX_EN)   rdata_o = en_w;
    for (int k = 0; k < int'(N_PRIO_REG); k++)
      if (idx == IDX_W'(REG_PRIO + k)) rdata_o = prio_w[k];
  end

  for (genvar v = 0; v < N_VEC; v++) begin : g_prio_out
    assign prio_o[v*3 +: 3] = prio_q[v][4:2];
    assign sub_o[v*2 +: 2]  = prio_q[v][1:0];
  end

  assign flag_o      = flag_q;
  assign en_o        = en_q;
  assign rise_sel_o  = ctrl_q[N_EXT-1:0];
  assign mvec_o      = ctrl_q[CTRL_MVEC_BIT];
  assign shadow_en_o = ctrl_q[CTRL_SHADOW_BIT];

  // R8: a hardware pulse always leaves its flag set
  a_r8_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((flag_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R7: unimplemented control bits never become set
  a_r7_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_MASK) == '0);

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_VEC = 8,
  parameter int unsigned VEC_W = 3,
  parameter logic [N_SRC*VEC_W-1:0] SRC_VEC = '0
) (
  input  logic [N_SRC-1:0]   flag_i,
  input  logic [N_SRC-1:0]   en_i,
  input  logic [N_VEC*3-1:0] prio_i,
  input  logic [N_VEC*2-1:0] sub_i,
  input  logic [2:0]         cpu_lvl_i,
  output logic               found_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [2:0]         lvl_o
);

  logic [4:0] best_key;

  // descending scan with >= leaves the lowest source on ties
  always_comb begin
    logic [VEC_W-1:0] v;
    logic [2:0]       p;
    logic [1:0]       sb;
    found_o  = 1'b0;
    vec_o    = '0;
    lvl_o    = '0;
    best_key = '0;
    for (int s = int'(N_SRC) - 1; s >= 0; s--) begin
      v  = SRC_VEC[s*VEC_W +: VEC_W];
      p  = prio_i[int'(v)*3 +: 3];
      sb = sub_i[int'(v)*2 +: 2];
      if (flag_i[s] && en_i[s] && (p > cpu_lvl_i) && (!found_o || {p, sb} >= best_key)) begin
        found_o  = 1'b1;
        best_key = {p, sb};
        vec_o    = v;
        lvl_o    = p;
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import ivc_pkg::*; #(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned N_VEC    = 8,
  parameter int unsigned VEC_W    = 3,
  parameter int unsigned N_EXT    = 5,
  parameter int unsigned EXT_BASE = 24,
  parameter int unsigned ADDR_W   = 5,
  parameter logic [N_SRC*VEC_W-1:0] SRC_VEC = default_map()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_pulse_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [2:0]        cpu_lvl_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [2:0]        irq_lvl_o,
  output logic              shadow_sel_o
);

  logic [N_SRC-1:0]   flag, en, hw_set;
  logic [N_VEC*3-1:0] prio;
  logic [N_VEC*2-1:0] sub;
  logic [N_EXT-1:0]   rise_sel, ext_hit;
  logic               mvec, shadow_en;
  logic               found, fire;
  logic [VEC_W-1:0]   win_vec;
  logic [2:0]         win_lvl;

  ivc_edge_det #(.N_EXT(N_EXT)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .rise_sel_i (rise_sel),
    .hit_o      (ext_hit)
  );

  always_comb begin
    hw_set = src_pulse_i;
    for (int k = 0; k < int'(N_EXT); k++) hw_set[EXT_BASE + k] = hw_set[EXT_BASE + k] | ext_hit[k];
  end

  ivc_regfile #(.N_SRC(N_SRC), .N_VEC(N_VEC), .N_EXT(N_EXT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .hw_set_i    (hw_set),
    .flag_o      (flag),
    .en_o        (en),
    .prio_o      (prio),
    .sub_o       (sub),
    .rise_sel_o  (rise_sel),
    .mvec_o      (mvec),
    .shadow_en_o (shadow_en)
  );

  ivc_arbiter #(.N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_W(VEC_W), .SRC_VEC(SRC_VEC)) u_arb (
    .flag_i    (flag),
    .en_i      (en),
    .prio_i    (prio),
    .sub_i     (sub),
    .cpu_lvl_i (cpu_lvl_i),
    .found_o   (found),
    .vec_o     (win_vec),
    .lvl_o     (win_lvl)
  );

  assign fire = found & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o        <= 1'b0;
      irq_vec_o    <= '0;
      irq_lvl_o    <= '0;
      shadow_sel_o <= 1'b0;
    end else begin
      irq_o        <= fire;
      irq_vec_o    <= (fire && mvec) ? win_vec : '0;
      irq_lvl_o    <= fire ? win_lvl : '0;
      shadow_sel_o <= fire && shadow_en && (win_lvl == 3'd7);
    end
  end

  // R2: a request is always above the level the cpu ran at when it was taken
  a_r2_above_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o > $past(cpu_lvl_i)));

  // R3: level zero is never requested
  a_r3_no_zero_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o != 3'd0));

  // R6: single-vector mode reports vector 0
  a_r6_single_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mvec |=> (irq_vec_o == '0));

  // R11: acknowledge opens a one-cycle gap
  a_r11_ack_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);

  // R12: shadow select only with a level-7 request
  a_r12_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_sel_o |-> (irq_o && irq_lvl_o == 3'd7));

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int C_CTRL = 0, C_FLAG = 1, C_EN = 2, C_PRIO0 = 3, C_PRIO1 = 4;
  localparam int W_WR = 0, W_CLR = 1, W_SET = 2, W_INV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_pulse = '0;
  logic [4:0]  ext_pin = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  cpu_lvl = '0;
  logic        ack = 1'b0;
  logic        irq;
  logic [2:0]  irq_vec, irq_lvl;
  logic        shadow_sel;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  int         due_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .src_pulse_i  (src_pulse),
    .ext_pin_i    (ext_pin),
    .reg_we_i     (reg_we),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .cpu_lvl_i    (cpu_lvl),
    .ack_i        (ack),
    .irq_o        (irq),
    .irq_vec_o    (irq_vec),
    .irq_lvl_o    (irq_lvl),
    .shadow_sel_o (shadow_sel)
  );

  // monitor: pops expected items once their edge has passed
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_PERIOD/4);
      while (due_q.size() > 0 && due_q[0] <= cyc) begin
        logic [7:0] e, a;
        string t;
        void'(due_q.pop_front());
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {irq, irq_vec, irq_lvl, shadow_sel};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s outputs {irq,vec,lvl,sh} actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: expected outputs after the next rising edge
  task automatic expect_out(string tag, logic i, logic [2:0] v, logic [2:0] l, logic s);
    due_q.push_back(cyc + 1);
    exp_q.push_back({i, v, l, s});
    tag_q.push_back(tag);
    step();
  endtask

  task automatic wr(int idx, int op, logic [31:0] d);
    reg_we    = 1'b1;
    reg_addr  = 5'(idx*4 + op);
    reg_wdata = d;
    step();
    reg_we    = 1'b0;
  endtask

  task automatic rd(string tag, int idx, logic [31:0] e);
    reg_addr = 5'(idx*4);
    #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic pulse(logic [31:0] m);
    src_pulse = m;
    step();
    src_pulse = '0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd("R1 ctrl", C_CTRL, 32'h0);
    rd("R1 flag", C_FLAG, 32'h0);
    rd("R1 en", C_EN, 32'h0);
    rd("R1 prio0", C_PRIO0, 32'h0);
    rd("R1 prio1", C_PRIO1, 32'h0);
    expect_out("R1 outputs", 0, 0, 0, 0);

    // R8 flag set by pulse, R3 level 0 blocks
    wr(C_EN, W_SET, 32'h20);
    pulse(32'h20);
    rd("R8 flag after pulse", C_FLAG, 32'h20);
    expect_out("R3 level zero", 0, 0, 0, 0);

    // R10 one cycle latency, R6 single-vector
    wr(C_PRIO0, W_WR, 32'h0000_0D00);
    chk("R10 not yet", {31'h0, irq}, 32'h0);
    expect_out("R6 single vector", 1, 0, 3, 0);

    wr(C_CTRL, W_SET, 32'h100);
    rd("R7 ctrl set", C_CTRL, 32'h100);
    expect_out("R6 multi vector", 1, 1, 3, 0);

    // R2 equal level held pending, released on drop
    cpu_lvl = 3'd3;
    expect_out("R2 equal level", 0, 0, 0, 0);
    rd("R2 still pending", C_FLAG, 32'h20);
    cpu_lvl = 3'd2;
    expect_out("R2 level drop", 1, 1, 3, 0);

    // R4 higher level wins
    wr(C_EN, W_SET, 32'h200);
    wr(C_PRIO0, W_SET, 32'h0014_0000);
    rd("R7 prio set alias", C_PRIO0, 32'h0014_0D00);
    pulse(32'h200);
    expect_out("R4 level", 1, 2, 5, 0);

    // R4 sub-level decides at equal level
    wr(C_PRIO0, W_WR, 32'h0014_1500);
    expect_out("R4 sub-level", 1, 1, 5, 0);

    // R4 full tie goes to lower source
    wr(C_PRIO0, W_WR, 32'h0015_1500);
    expect_out("R4 source order", 1, 1, 5, 0);

    // R5 shared vector
    wr(C_FLAG, W_CLR, 32'h20);
    expect_out("R5 after clear", 1, 2, 5, 0);
    wr(C_EN, W_SET, 32'h40);
    pulse(32'h40);
    rd("R5 flags", C_FLAG, 32'h240);
    expect_out("R5 shared level", 1, 1, 5, 0);

    // R11 acknowledge gap
    ack = 1'b1;
    expect_out("R11 gap", 0, 0, 0, 0);
    ack = 1'b0;
    expect_out("R11 resume", 1, 1, 5, 0);

    // R7 toggle alias
    wr(C_EN, W_INV, 32'h40);
    rd("R7 toggle", C_EN, 32'h220);
    expect_out("R7 after toggle", 1, 2, 5, 0);

    // R8 clear and pulse same cycle
    reg_we    = 1'b1;
    reg_addr  = 5'(C_FLAG*4 + W_CLR);
    reg_wdata = 32'h200;
    src_pulse = 32'h200;
    step();
    reg_we    = 1'b0;
    src_pulse = '0;
    rd("R8 set beats clear", C_FLAG, 32'h240);
    wr(C_FLAG, W_CLR, 32'h40);
    rd("R8 software clear", C_FLAG, 32'h200);
    expect_out("R8 outputs", 1, 2, 5, 0);

    // R9 external edges, falling polarity on pin 0
    wr(C_EN, W_SET, 32'h0300_0000);
    wr(C_PRIO1, W_WR, 32'h001C_0000);
    ext_pin[0] = 1'b1;
    step();
    rd("R9 wrong edge ignored", C_FLAG, 32'h200);
    expect_out("R9 no request", 1, 2, 5, 0);
    ext_pin[0] = 1'b0;
    step();
    rd("R9 falling edge", C_FLAG, 32'h0100_0200);
    expect_out("R9 pin request", 1, 6, 7, 0);

    // R12 shadow select
    wr(C_CTRL, W_SET, 32'h1000);
    rd("R12 ctrl", C_CTRL, 32'h1100);
    expect_out("R12 shadow", 1, 6, 7, 1);

    // R9 rising polarity on pin 1
    wr(C_CTRL, W_SET, 32'h2);
    ext_pin[1] = 1'b1;
    step();
    rd("R9 rising edge", C_FLAG, 32'h0300_0200);
    wr(C_FLAG, W_CLR, 32'h0200_0000);
    ext_pin[1] = 1'b0;
    step();
    rd("R9 falling ignored", C_FLAG, 32'h0100_0200);

    // R2 top level blocks all
    cpu_lvl = 3'd7;
    expect_out("R2 level 7 blocks", 0, 0, 0, 0);
    cpu_lvl = 3'd6;
    expect_out("R2 level 6", 1, 6, 7, 1);
    cpu_lvl = 3'd0;

    // R3 disabling a vector by level 0
    wr(C_PRIO1, W_CLR, 32'h001C_0000);
    expect_out("R3 vector off", 1, 2, 5, 0);

    // R6 back to single vector
    wr(C_CTRL, W_CLR, 32'h100);
    expect_out("R6 single again", 1, 0, 5, 0);

    repeat (3) step();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule